// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block decides whether the receive twisted pair has been wired backwards and drives an invert control for the receive data path. It watches two event streams that front-end detectors produce: link-pulse events tagged with their polarity, and end-of-packet events that carry a flag saying the end delimiter was well formed, plus the delimiter's polarity. A link-fail level from the link monitor returns the block to its starting state.

The decision runs in two stages. While the link is down, a run of identical-polarity link pulses brings the link up and seeds the invert setting. Once the link is up, the block stays armed. The first well-formed end delimiter sets the invert control outright. Every later well-formed delimiter either confirms the setting or replaces it. After two consecutive agreeing delimiters the setting locks, and it stays locked until the next link fail or reset. The invert control also drives a reversed-polarity status flag, so an LED or a register can show it. The block reports the lock state and whether each link pulse was accepted in the locked-in polarity.

The asynchronous active-low reset is released synchronously through a two-flop stage, so internal state leaves reset on the second rising clock edge after `rst_n` goes high. Every other state change shows on the outputs one clock after the event that causes it.

Top module: `rx_pol_ctrl`

## Requirements
- R1: While reset is applied, and after it is released with idle inputs, `rx_invert`, `pol_reversed`, `pol_locked` and `link_up` are all 0.
- R2: With `link_up` low, the link comes up (`link_up` goes to 1 one clock later) on the RUN_LEN-th (default 5) consecutive link pulse of identical polarity. A pulse whose polarity differs from the previous one restarts the run at one.
- R3: When the link comes up, `rx_invert` takes the polarity of that pulse run (`pulse_neg`=1 means reversed, giving `rx_invert`=1).
- R4: `beat_ok` is 1 exactly when `link_up` is 1 and a pulse arrives whose `pulse_neg` equals `rx_invert`. End-of-packet events that arrive while `link_up` is 0 change nothing.
- R5: The first valid end delimiter (`eop_vld`=1, `eop_good`=1) after reset or link fail sets `rx_invert` to `eop_neg`, whatever the previous setting, and leaves `pol_locked` at 0.
- R6: After that, a valid delimiter whose `eop_neg` equals `rx_invert` sets `pol_locked`. One that differs sets `rx_invert` to `eop_neg`, counts as the new first delimiter, and leaves `pol_locked` at 0.
- R7: An end-of-packet event with `eop_good`=0 changes neither `rx_invert` nor the agreement count: the next valid delimiter behaves as if the invalid one never came.
- R8: While `pol_locked` is 1, delimiters and pulses leave `rx_invert` unchanged.
- R9: `link_fail`=1 clears `link_up`, `pol_locked` and the agreement count on the next clock and re-arms the algorithm. `rx_invert` keeps its value until new pulses or delimiters set it. `link_fail` has priority over any event in the same cycle.
- R10: `pol_reversed` equals `rx_invert` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_fail | input | 1 | Link monitor reports loss of link |
| pulse_vld | input | 1 | One-cycle link-pulse event |
| pulse_neg | input | 1 | Polarity of the link pulse, 1 = negative |
| eop_vld | input | 1 | One-cycle end-of-packet event |
| eop_good | input | 1 | End delimiter was well formed |
| eop_neg | input | 1 | Polarity of the end delimiter, 1 = negative |
| rx_invert | output | 1 | Invert control for the receive data path |
| pol_reversed | output | 1 | Status flag, 1 while reversal is applied |
| pol_locked | output | 1 | Polarity decision is locked |
| link_up | output | 1 | Link pass state |
| beat_ok | output | 1 | Current pulse accepted in the locked-in polarity |

## Verification
The bench goes after a pulse run that breaks on a polarity change one pulse short of the limit. A design that does not restart the run would bring the link up early with the wrong seed. It sends a disagreeing second delimiter and then an agreeing third one. A design that locks on any two valid packets, or one that keeps the old polarity, would lock onto the wrong setting. Invalid delimiters sit between valid ones, so a design that counts them toward agreement would lock too soon. After lock, and in the same cycle as a link fail, it sends delimiters of the other polarity. A design with the wrong priority would flip the invert control or stay locked across the fail. A long stretch of mixed random events is then checked cycle by cycle against a behavioural model.

// File: rtl/rx_pol_pkg.sv
package rx_pol_pkg;
  typedef enum logic {
    LNK_DOWN = 1'b0,
    LNK_UP   = 1'b1
  } lnk_state_e;
endpackage

// File: rtl/rx_pol_pulse_run.sv
module rx_pol_pulse_run
  import rx_pol_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_fail,
  input  logic pulse_vld,
  input  logic pulse_neg,
  input  logic cur_inv,
  output logic link_up,
  output logic seed_vld,
  output logic seed_neg,
  output logic beat_ok
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  lnk_state_e       st_q, st_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             last_q, last_d;
  logic             reg_en;
  logic             seed_hit;

  always_comb begin
    st_d     = st_q;
    run_d    = run_q;
    last_d   = last_q;
    seed_hit = 1'b0;
    if (link_fail) begin
      st_d  = LNK_DOWN;
      run_d = '0;
    end else if (st_q == LNK_DOWN && pulse_vld) begin
      last_d = pulse_neg;
      if (run_q != '0 && pulse_neg == last_q) run_d = run_q + 1'b1;
      else                                    run_d = RUN_W'(1);
      if (run_d == RUN_W'(RUN_LEN)) begin
        seed_hit = 1'b1;
        st_d     = LNK_UP;
        run_d    = '0;
      end
    end
  end

  assign reg_en = link_fail | pulse_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LNK_DOWN;
      run_q  <= '0;
      last_q <= 1'b0;
    end else if (reg_en) begin
      st_q   <= st_d;
      run_q  <= run_d;
      last_q <= last_d;
    end
  end

  assign link_up  = (st_q == LNK_UP);
  assign seed_vld = seed_hit;
  assign seed_neg = pulse_neg;
  assign beat_ok  = link_up & pulse_vld & (pulse_neg == cur_inv);

  assert_fail_drops_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |=> !link_up);
  assert_up_needs_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(pulse_vld));
  assert_seed_brings_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seed_vld |=> link_up);
endmodule

// File: rtl/rx_pol_delim_lock.sv
module rx_pol_delim_lock #(
  parameter int LOCK_RUN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_fail,
  input  logic link_up,
  input  logic seed_vld,
  input  logic seed_neg,
  input  logic eop_vld,
  input  logic eop_good,
  input  logic eop_neg,
  output logic invert,
  output logic locked
);
  localparam int AGR_W = $clog2(LOCK_RUN + 1);

  logic             inv_q, inv_d;
  logic             lock_q, lock_d;
  logic [AGR_W-1:0] agr_q, agr_d;
  logic             take_eop;
  logic             reg_en;

  assign take_eop = link_up & ~lock_q & eop_vld & eop_good;

  always_comb begin
    inv_d  = inv_q;
    lock_d = lock_q;
    agr_d  = agr_q;
    if (link_fail) begin
      lock_d = 1'b0;
      agr_d  = '0;
    end else if (seed_vld) begin
      inv_d = seed_neg;
    end else if (take_eop) begin
      if (agr_q != '0 && eop_neg == inv_q) begin
        agr_d = agr_q + 1'b1;
        if (agr_d == AGR_W'(LOCK_RUN)) lock_d = 1'b1;
      end else begin
        inv_d = eop_neg;
        agr_d = AGR_W'(1);
      end
    end
  end

  assign reg_en = link_fail | seed_vld | take_eop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q  <= 1'b0;
      lock_q <= 1'b0;
      agr_q  <= '0;
    end else if (reg_en) begin
      inv_q  <= inv_d;
      lock_q <= lock_d;
      agr_q  <= agr_d;
    end
  end

  assign invert = inv_q;
  assign locked = lock_q;

  assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !link_fail) |=> $stable(invert));
  assert_fail_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |=> (!locked && agr_q == '0));
  assert_bad_delim_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_vld && !eop_good && !link_fail && !seed_vld) |=> ($stable(invert) && $stable(agr_q)));
  assert_lock_needs_eop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(eop_vld && eop_good));
endmodule

// File: rtl/rx_pol_ctrl.sv
module rx_pol_ctrl #(
  parameter int RUN_LEN  = 5,
  parameter int LOCK_RUN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_fail,
  input  logic pulse_vld,
  input  logic pulse_neg,
  input  logic eop_vld,
  input  logic eop_good,
  input  logic eop_neg,
  output logic rx_invert,
  output logic pol_reversed,
  output logic pol_locked,
  output logic link_up,
  output logic beat_ok
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       seed_vld;
  logic       seed_neg;
  logic       inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  rx_pol_pulse_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .link_fail (link_fail),
    .pulse_vld (pulse_vld),
    .pulse_neg (pulse_neg),
    .cur_inv   (inv),
    .link_up   (link_up),
    .seed_vld  (seed_vld),
    .seed_neg  (seed_neg),
    .beat_ok   (beat_ok)
  );

  rx_pol_delim_lock #(.LOCK_RUN(LOCK_RUN)) u_lock (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .link_fail (link_fail),
    .link_up   (link_up),
    .seed_vld  (seed_vld),
    .seed_neg  (seed_neg),
    .eop_vld   (eop_vld),
    .eop_good  (eop_good),
    .eop_neg   (eop_neg),
    .invert    (inv),
    .locked    (pol_locked)
  );

  assign rx_invert    = inv;
  assign pol_reversed = inv;

  assert_eop_while_down_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!link_up && !pulse_vld) |=> ($stable(rx_invert) && $stable(pol_locked)));
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_int_n |-> (!rx_invert && !pol_locked && !link_up));
endmodule

// File: tb/rx_pol_ctrl_test.sv
module rx_pol_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic link_fail, pulse_vld, pulse_neg, eop_vld, eop_good, eop_neg;
  logic rx_invert, pol_reversed, pol_locked, link_up, beat_ok;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_up, m_run, m_last, m_inv, m_lock, m_agree;

  always #2.5 clk = ~clk;

  rx_pol_ctrl uut (
    .clk(clk), .rst_n(rst_n), .link_fail(link_fail),
    .pulse_vld(pulse_vld), .pulse_neg(pulse_neg),
    .eop_vld(eop_vld), .eop_good(eop_good), .eop_neg(eop_neg),
    .rx_invert(rx_invert), .pol_reversed(pol_reversed),
    .pol_locked(pol_locked), .link_up(link_up), .beat_ok(beat_ok)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_up = 0; m_run = 0; m_last = 0; m_inv = 0; m_lock = 0; m_agree = 0;
    end else if (link_fail) begin
      m_up = 0; m_run = 0; m_lock = 0; m_agree = 0;
    end else if (m_up == 0) begin
      if (pulse_vld) begin
        if (m_run > 0 && int'(pulse_neg) == m_last) m_run = m_run + 1;
        else m_run = 1;
        m_last = int'(pulse_neg);
        if (m_run >= 5) begin
          m_up = 1; m_inv = int'(pulse_neg); m_run = 0;
        end
      end
    end else if (eop_vld && eop_good && m_lock == 0) begin
      if (m_agree > 0 && int'(eop_neg) == m_inv) begin
        m_agree = m_agree + 1;
        if (m_agree >= 2) m_lock = 1;
      end else begin
        m_inv = int'(eop_neg); m_agree = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int exp_beat;
    exp_beat = (m_up == 1 && pulse_vld && int'(pulse_neg) == m_inv) ? 1 : 0;
    chk(int'(rx_invert) == m_inv, cur_req, int'(rx_invert), m_inv, "rx_invert");
    chk(int'(pol_reversed) == m_inv, "R10", int'(pol_reversed), m_inv, "pol_reversed");
    chk(int'(pol_locked) == m_lock, cur_req, int'(pol_locked), m_lock, "pol_locked");
    chk(int'(link_up) == m_up, cur_req, int'(link_up), m_up, "link_up");
    chk(int'(beat_ok) == exp_beat, cur_req, int'(beat_ok), exp_beat, "beat_ok");
  endtask

  task automatic step(input logic p, input logic pn, input logic e, input logic eg,
                      input logic en, input logic lf);
    @(negedge clk);
    compare();
    pulse_vld = p; pulse_neg = pn; eop_vld = e; eop_good = eg; eop_neg = en; link_fail = lf;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic pulses(input int n, input logic neg);
    for (int i = 0; i < n; i++) begin
      step(1, neg, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic eop(input logic good, input logic neg);
    step(0, 0, 1, good, neg, 0);
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_now(input string tag, input int inv, input int lock, input int up);
    chk(int'(rx_invert) == inv, tag, int'(rx_invert), inv, "direct rx_invert");
    chk(int'(pol_locked) == lock, tag, int'(pol_locked), lock, "direct pol_locked");
    chk(int'(link_up) == up, tag, int'(link_up), up, "direct link_up");
  endtask

  initial begin
    #500us;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    link_fail = 0; pulse_vld = 0; pulse_neg = 0; eop_vld = 0; eop_good = 0; eop_neg = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    expect_now("R1", 0, 0, 0);
    rst_n = 1'b1;
    idle(4);
    expect_now("R1", 0, 0, 0);

    // R4: delimiters while link down are ignored
    cur_req = "R4";
    eop(1, 1);
    expect_now("R4", 0, 0, 0);

    // R2: run broken one short of the limit, then full negative run
    cur_req = "R2";
    pulses(4, 0);
    pulses(1, 1);
    expect_now("R2", 0, 0, 0);
    pulses(3, 1);
    expect_now("R2", 0, 0, 0);
    cur_req = "R3";
    pulses(1, 1);
    expect_now("R3", 1, 0, 1);

    // R4: beat acceptance by polarity
    cur_req = "R4";
    step(1, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(beat_ok == 1'b0, "R4", int'(beat_ok), 0, "beat wrong polarity");
    step(1, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk(beat_ok == 1'b1, "R4", int'(beat_ok), 1, "beat right polarity");
    step(0, 0, 0, 0, 0, 0);

    // R7: invalid delimiter no effect
    cur_req = "R7";
    eop(0, 0);
    expect_now("R7", 1, 0, 1);

    // R5: first valid delimiter overrides seed
    cur_req = "R5";
    eop(1, 0);
    expect_now("R5", 0, 0, 1);
    cur_req = "R7";
    eop(0, 1);
    expect_now("R7", 0, 0, 1);

    // R6: disagree then agree
    cur_req = "R6";
    eop(1, 1);
    expect_now("R6", 1, 0, 1);
    eop(1, 1);
    expect_now("R6", 1, 1, 1);

    // R8: locked ignores delimiters
    cur_req = "R8";
    eop(1, 0);
    eop(1, 0);
    expect_now("R8", 1, 1, 1);

    // R9: link fail with simultaneous delimiter
    cur_req = "R9";
    step(0, 0, 1, 1, 0, 1);
    step(0, 0, 0, 0, 0, 0);
    expect_now("R9", 1, 0, 0);
    pulses(5, 0);
    expect_now("R9", 0, 0, 1);
    cur_req = "R5";
    eop(1, 1);
    expect_now("R5", 1, 0, 1);
    cur_req = "R6";
    eop(1, 1);
    expect_now("R6", 1, 1, 1);

    // mixed random traffic against model
    cur_req = "R2/R6";
    begin
      logic bias;
      bias = 0;
      for (int i = 0; i < 4000; i++) begin
        int r;
        r = int'($urandom_range(0, 99));
        if ($urandom_range(0, 15) == 0) bias = ~bias;
        if (r < 2)       step(0, 0, 0, 0, 0, 1);
        else if (r < 45) step(1, ($urandom_range(0, 7) == 0) ? ~bias : bias, 0, 0, 0, 0);
        else if (r < 75) step(0, 0, 1, ($urandom_range(0, 3) != 0), $urandom_range(0, 1), 0);
        else             step(0, 0, 0, 0, 0, 0);
      end
    end
    idle(2);

    // R1: reset mid-run
    cur_req = "R1";
    @(negedge clk);
    rst_n = 1'b0;
    link_fail = 0; pulse_vld = 0; eop_vld = 0;
    @(negedge clk);
    expect_now("R1", 0, 0, 0);
    rst_n = 1'b1;
    idle(4);
    expect_now("R1", 0, 0, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule